// File: doc/BRIEF.md
# Guarded Fixed-Point Multiply-Accumulate

This block computes dot products of 16-bit two's complement fractions, the inner loop of FIR filtering and correlation. Each cycle it can take one data sample and one coefficient, both in Q1.15. It forms their exact product and adds it into a wide accumulator. The accumulator carries eight guard bits above the product width. A running sum may therefore pass beyond the range of one word and come back without losing information.

A clear input starts a new dot product. When clear and valid are high together, the current product replaces the accumulator contents. When clear is high without valid, the accumulator empties to zero. An output stage narrows the accumulator to a 16-bit word. A mode input picks rounding or truncation. A value that does not fit is pinned to the largest positive or most negative code and never wraps. A sticky flag records that pinning happened since the last clear.

Top module: `gmac_unit`

## Requirements
- R1: The accumulator accepts one operand pair per cycle while `in_vld` is high. `dout` shows the narrowed accumulator one clock edge after the pair is presented.
- R2: The product of `din_a` and `din_b` is exact. It is doubled to Q1.31 and sign-extended to 40 bits before it is added. This includes -1.0 × -1.0 = +1.0, which narrows (saturated) to 16'h7FFF.
- R3: Eight guard bits above the 32-bit doubled product let intermediate sums of up to 2^8 full-scale products exceed ±1.0. When later terms bring the sum back into range, the narrowed result is exact.
- R4: `in_clr` with `in_vld` loads the accumulator with the current product. `in_clr` without `in_vld` sets the accumulator to zero.
- R5: With `rnd_mode` = 0 (truncate), `dout` is floor(acc / 2^16), which rounds toward minus infinity. For example, an accumulator of -2^15 gives 16'hFFFF.
- R6: With `rnd_mode` = 1 (round), `dout` is floor((acc + 2^15) / 2^16). A value exactly half an output LSB rounds upward: 2^15 gives 16'h0001 and -2^15 gives 16'h0000.
- R7: A narrowed value above +32767 gives 16'h7FFF. A narrowed value below -32768 gives 16'h8000.
- R8: `sat_flag` rises in the same cycle as a saturated `dout`. It stays high until a cycle with `in_clr`, which recomputes it from the new accumulator value alone.
- R9: Synchronous `rst` empties the accumulator and drives `dout` and `sat_flag` to 0.
- R10: With `in_vld` low and `in_clr` low, the accumulator holds and the operand inputs are ignored. `dout` is re-narrowed every cycle with the current `rnd_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand pair valid this cycle |
| in_clr | input | 1 | Start a new dot product |
| rnd_mode | input | 1 | 0 truncate, 1 round half up |
| din_a | input | 16 | Data sample, Q1.15 |
| din_b | input | 16 | Coefficient, Q1.15 |
| dout | output | 16 | Narrowed, saturated result, Q1.15 |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
The assertions check on every cycle that:
- the accumulator holds when idle;
- a clear loads the product or zero;
- an accumulate adds exactly the registered product;
- the doubled product never leaves ±2^31;
- a rising flag comes with one of the two limit codes;
- the flag stays set until a clear.

Some behaviour depends on specific values and only the bench scenarios can show it:
- correct rounding at exact ties;
- truncation toward minus infinity;
- a sum that passes +1.0 and returns to an exact in-range value through the guard bits;
- the -1.0 × -1.0 corner.

// File: rtl/gmac_pkg.sv
package gmac_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned GUARD_W = 8;

  typedef enum logic {
    NARROW_TRUNC = 1'b0,
    NARROW_ROUND = 1'b1
  } narrow_mode_e;
endpackage

// File: rtl/gmac_mult.sv
module gmac_mult #(
  parameter int unsigned DW   = 16,
  parameter int unsigned ACCW = 40
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic [ACCW-1:0] prod
);
  localparam int unsigned PW = 2 * DW;
  localparam int unsigned XW = ACCW - PW;

  logic signed [PW-1:0] full;
  logic [ACCW-1:0]      ext;

  always_comb begin
    full = $signed(a) * $signed(b);
    ext  = {{XW{full[PW-1]}}, full};
    // drop the duplicated sign bit: Q2.30 -> Q1.31 in a wide word
    prod = {ext[ACCW-2:0], 1'b0};
  end
endmodule

// File: rtl/gmac_accum.sv
module gmac_accum #(
  parameter int unsigned ACCW = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vld,
  input  logic            clr,
  input  logic [ACCW-1:0] prod,
  output logic [ACCW-1:0] acc_d,
  output logic [ACCW-1:0] acc_q
);
  always_comb begin
    if (clr)      acc_d = vld ? prod : '0;
    else if (vld) acc_d = acc_q + prod;
    else          acc_d = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

  // R10: idle cycle keeps the sum
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(vld) && !$past(clr)) |-> $stable(acc_q));

  // R4: clear with valid loads the product
  a_r4_clr_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld) && $past(clr)) |-> acc_q == $past(prod));

  // R4: clear alone empties the sum
  a_r4_clr_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(vld) && $past(clr)) |-> acc_q == '0);

  // R1: one accumulate per valid cycle
  a_r1_accumulate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vld) && !$past(clr)) |-> acc_q == $past(acc_q) + $past(prod));
endmodule

// File: rtl/gmac_narrow.sv
module gmac_narrow
  import gmac_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned ACCW = 40
) (
  input  logic [ACCW-1:0] acc,
  input  narrow_mode_e    mode,
  output logic [DW-1:0]   y,
  output logic            sat
);
  localparam int unsigned SH = DW;            // Q?.31 -> Q?.15
  localparam int unsigned EW = ACCW + 1;      // room for the rounding carry
  localparam int unsigned QW = EW - SH;       // width after dropping fraction
  localparam logic [DW-1:0] MAXC = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINC = {1'b1, {(DW-1){1'b0}}};
  localparam logic [EW-1:0] HALF = EW'(1) << (SH - 1);

  logic signed [EW-1:0] accx;
  logic signed [EW-1:0] biased;
  logic signed [QW-1:0] q;
  logic                 fits;

  always_comb begin
    accx   = $signed({acc[ACCW-1], acc});
    biased = (mode == NARROW_ROUND) ? accx + $signed(HALF) : accx;
    q      = QW'(biased >>> SH);
    fits   = (q[QW-1:DW-1] == '0) || (q[QW-1:DW-1] == '1);
    sat    = !fits;
    if (fits)       y = q[DW-1:0];
    else if (q[QW-1]) y = MINC;
    else            y = MAXC;
  end
endmodule

// File: rtl/gmac_unit.sv
module gmac_unit
  import gmac_pkg::*;
#(
  parameter int unsigned DW    = WORD_W,
  parameter int unsigned GUARD = GUARD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic          in_clr,
  input  logic          rnd_mode,
  input  logic [DW-1:0] din_a,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] dout,
  output logic          sat_flag
);
  localparam int unsigned ACCW = 2 * DW + GUARD;
  localparam logic [DW-1:0] MAXC = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINC = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [ACCW-1:0] PMAX = ACCW'(1) <<< (2 * DW - 1);

  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] acc_d;
  logic [ACCW-1:0] acc_q;
  logic [DW-1:0]   y_d;
  logic            sat_d;
  narrow_mode_e    mode;

  assign mode = narrow_mode_e'(rnd_mode);

  gmac_mult #(.DW(DW), .ACCW(ACCW)) u_mult (
    .a(din_a), .b(din_b), .prod(prod)
  );

  gmac_accum #(.ACCW(ACCW)) u_accum (
    .clk(clk), .rst(rst), .vld(in_vld), .clr(in_clr),
    .prod(prod), .acc_d(acc_d), .acc_q(acc_q)
  );

  gmac_narrow #(.DW(DW), .ACCW(ACCW)) u_narrow (
    .acc(acc_d), .mode(mode), .y(y_d), .sat(sat_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      sat_flag <= 1'b0;
    end else begin
      dout     <= y_d;
      sat_flag <= (in_clr ? 1'b0 : sat_flag) | sat_d;
    end
  end

  // R2: doubled product stays within +-1.0 in Q1.31
  a_r2_prod_range: assert property (@(posedge clk) disable iff (rst)
    ($signed(prod) <= PMAX) && ($signed(prod) >= -PMAX));

  // R7: a fresh saturation shows a limit code
  a_r7_sat_code: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> (dout == MAXC || dout == MINC));

  // R8: flag is sticky until a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sat_flag) && !$past(in_clr)) |-> sat_flag);
endmodule

// File: tb/test_gmac_unit.sv
module test_gmac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic        in_clr = 1'b0;
  logic        rnd_mode = 1'b0;
  logic [15:0] din_a = '0;
  logic [15:0] din_b = '0;
  logic [15:0] dout;
  logic        sat_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gmac_unit i_gmac_unit (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_clr(in_clr),
    .rnd_mode(rnd_mode), .din_a(din_a), .din_b(din_b),
    .dout(dout), .sat_flag(sat_flag)
  );

  // row: vld clr mode a b exp_dout exp_flag
  localparam int NV = 17;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1,1'b1,1'b0,16'h4000,16'h4000,16'h2000,1'b0},
    {1'b1,1'b0,1'b0,16'h4000,16'h4000,16'h4000,1'b0},
    {1'b1,1'b0,1'b0,16'h4000,16'h4000,16'h6000,1'b0},
    {1'b1,1'b0,1'b0,16'h4000,16'h4000,16'h7FFF,1'b1},
    {1'b1,1'b0,1'b0,16'hC000,16'h4000,16'h6000,1'b1},
    {1'b1,1'b1,1'b0,16'h0001,16'h0001,16'h0000,1'b0},
    {1'b1,1'b0,1'b1,16'h0001,16'h4000,16'h0001,1'b0},
    {1'b0,1'b0,1'b1,16'h7FFF,16'h7FFF,16'h0001,1'b0},
    {1'b0,1'b0,1'b0,16'h7FFF,16'h7FFF,16'h0000,1'b0},
    {1'b1,1'b1,1'b1,16'h0001,16'h4000,16'h0001,1'b0},
    {1'b1,1'b1,1'b0,16'hFFFF,16'h4000,16'hFFFF,1'b0},
    {1'b1,1'b1,1'b1,16'hFFFF,16'h4000,16'h0000,1'b0},
    {1'b1,1'b1,1'b0,16'h8000,16'h8000,16'h7FFF,1'b1},
    {1'b1,1'b1,1'b0,16'h8000,16'h7FFF,16'h8001,1'b0},
    {1'b1,1'b0,1'b0,16'h8000,16'h7FFF,16'h8000,1'b1},
    {1'b1,1'b0,1'b0,16'h8000,16'h8000,16'h8002,1'b1},
    {1'b0,1'b1,1'b0,16'h1234,16'h5678,16'h0000,1'b0}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 12:  return "R2";
      1, 2:   return "R1";
      3, 14:  return "R7";
      4:      return "R3";
      5, 15:  return "R8";
      6, 9, 11: return "R6";
      7:      return "R10";
      8, 10, 13: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(logic v, logic c, logic m, logic [15:0] a, logic [15:0] b);
    in_vld = v; in_clr = c; rnd_mode = m; din_a = a; din_b = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL R1: watchdog expired, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9", dout, 16'h0000);
    chk("R9", {15'd0, sat_flag}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][51], VEC[i][50], VEC[i][49], VEC[i][48:33], VEC[i][32:17]);
      chk(row_tag(i), dout, VEC[i][16:1]);
      chk("R8", {15'd0, sat_flag}, {15'd0, VEC[i][0]});
    end

    // R3: guard bits carry 128 near-full-scale products and return exactly
    for (int k = 0; k < 128; k++)
      drive(1'b1, k == 0, 1'b0, 16'h7FFF, 16'h7FFF);
    chk("R3", dout, 16'h7FFF);
    for (int k = 0; k < 128; k++)
      drive(1'b1, 1'b0, 1'b0, 16'h8001, 16'h7FFF);
    chk("R3", dout, 16'h0000);
    chk("R8", {15'd0, sat_flag}, 16'h0001);

    // R9: mid-run reset empties the sum
    drive(1'b1, 1'b0, 1'b0, 16'h4000, 16'h4000);
    rst = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 16'h4000, 16'h4000);
    chk("R9", dout, 16'h0000);
    chk("R9", {15'd0, sat_flag}, 16'h0000);
    rst = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 16'h4000, 16'h4000);
    chk("R9", dout, 16'h2000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule